// File: doc/BRIEF.md
# Half-Duplex MII Receive Framer

This block sits on the receive side of a 10/100 media-independent interface port that runs half duplex. It watches the data-valid strobe from the PHY and picks up a frame when the strobe rises while the port's own transmitter is idle. While the strobe is high, it captures one 4-bit nibble on each rising receive-clock edge. It pairs the nibbles into bytes and sends them out as a stream of single-cycle beats, with start and end markers.

When the strobe drops, the last byte goes out with the end marker. That same beat carries three pieces of status: whether the PHY flagged a receive error anywhere inside the frame, whether the frame held an odd number of nibbles, and the frame length in bytes.

A strobe rise that happens while the local transmitter is active is the port hearing its own traffic. The block discards that whole event until the strobe falls again.

Top module: `mii_rx_framer`

## Requirements
- R1: While reset is held, and after it is released with no frame received, out_valid, out_sof, out_eof, out_err and out_align_err are 0 and out_len is 0.
- R2: A frame is accepted when rx_dv is 1 at a clock edge where the block was idle and tx_active is 0. Nibbles are taken from rxd at every edge with rx_dv=1. Each output byte is {later nibble, earlier nibble}: the first nibble of a pair goes in bits 3:0 and the second in bits 7:4.
- R3: Every output byte is one beat with out_valid=1. The first beat of a frame has out_sof=1, the last has out_eof=1, and no other beat carries either marker. A one-byte frame has both markers on the same beat.
- R4: The final nibble of a frame is the one sampled at the last edge with rx_dv=1. Values on rxd while rx_dv=0 produce no beats.
- R5: On the end beat, out_err is 1 exactly when rx_er was 1 at any edge with rx_dv=1 during that frame. rx_er while rx_dv=0 has no effect.
- R6: When a frame holds an odd number of nibbles, the end beat carries {4'h0, last nibble} and out_align_err=1. For an even count, out_align_err=0.
- R7: On the end beat, out_len equals the number of bytes in the frame (ceil(nibbles/2)), saturating at its maximum. On every other cycle, out_len=0, out_err=0 and out_align_err=0.
- R8: If rx_dv is 1 at an idle edge while tx_active is 1, nothing is output until rx_dv has been 0 at an edge, even if tx_active falls in the meantime.
- R9: A change of tx_active after a frame has been accepted has no effect on that frame.
- R10: The end beat appears in the cycle that follows the first edge with rx_dv=0. A non-final byte appears in the cycle that follows the edge sampling the first nibble of the next pair.
- R11: Two consecutive edges with rx_dv=0 are followed by a cycle with out_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock from the PHY |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_active | input | 1 | Local transmitter is sending |
| rx_dv | input | 1 | Receive data valid from the PHY |
| rx_er | input | 1 | Receive error from the PHY |
| rxd | input | 4 | Receive nibble |
| out_valid | output | 1 | Byte beat valid |
| out_data | output | 8 | Assembled byte |
| out_sof | output | 1 | First byte of frame |
| out_eof | output | 1 | Last byte of frame |
| out_err | output | 1 | Frame saw a receive error (end beat only) |
| out_align_err | output | 1 | Odd nibble count (end beat only) |
| out_len | output | LEN_W | Frame length in bytes (end beat only) |

## Verification
A stuck or missed nibble-phase bit shows up at once as swapped halves in out_data, or as one byte too many or too few. A lost pending-byte flag shows up by the end beat at the latest, as a missing eof or a wrong out_len. A gate state machine that fails to leave the discard state silences the next frame completely. One that leaves it too early emits beats for an echoed frame within two cycles. An error flag that does not clear leaks a spurious out_err into the next frame's end beat.

// File: rtl/mii_rx_pkg.sv
package mii_rx_pkg;
    localparam int NIB_W  = 4;
    localparam int BYTE_W = 2 * NIB_W;

    typedef enum logic [1:0] {
        GATE_IDLE = 2'd0,
        GATE_RECV = 2'd1,
        GATE_SKIP = 2'd2
    } gate_st_e;
endpackage

// File: rtl/mii_rx_gate.sv
module mii_rx_gate
    import mii_rx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rx_dv,
    input  logic tx_active,
    output logic start_o,
    output logic nib_o,
    output logic fin_o
);
    gate_st_e st_d, st_q;

    always_comb begin
        st_d    = st_q;
        start_o = 1'b0;
        nib_o   = 1'b0;
        fin_o   = 1'b0;
        case (st_q)
            GATE_IDLE: begin
                if (rx_dv) begin
                    if (tx_active) begin
                        st_d = GATE_SKIP;
                    end else begin
                        st_d    = GATE_RECV;
                        start_o = 1'b1;
                    end
                end
            end
            GATE_RECV: begin
                if (rx_dv) begin
                    nib_o = 1'b1;
                end else begin
                    fin_o = 1'b1;
                    st_d  = GATE_IDLE;
                end
            end
            GATE_SKIP: begin
                if (!rx_dv) st_d = GATE_IDLE;
            end
            default: st_d = GATE_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= GATE_IDLE;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/mii_rx_assembler.sv
module mii_rx_assembler
    import mii_rx_pkg::*;
#(
    parameter int LEN_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              nib_i,
    input  logic              fin_i,
    input  logic [NIB_W-1:0]  rxd,
    input  logic              rx_er,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_sof,
    output logic              out_eof,
    output logic              out_err,
    output logic              out_align_err,
    output logic [LEN_W-1:0]  out_len
);
    localparam logic [LEN_W-1:0] LEN_MAX = {LEN_W{1'b1}};

    typedef struct packed {
        logic              have_lo;
        logic [NIB_W-1:0]  lo;
        logic              pend;
        logic [BYTE_W-1:0] pend_byte;
        logic              first;
        logic              err;
        logic [LEN_W-1:0]  len;
        logic              o_valid;
        logic [BYTE_W-1:0] o_data;
        logic              o_sof;
        logic              o_eof;
        logic              o_err;
        logic              o_align;
        logic [LEN_W-1:0]  o_len;
    } asm_s;

    asm_s d, q;

    function automatic logic [LEN_W-1:0] sat_inc(input logic [LEN_W-1:0] v);
        return (v == LEN_MAX) ? v : v + 1'b1;
    endfunction

    always_comb begin
        d         = q;
        d.o_valid = 1'b0;
        d.o_data  = '0;
        d.o_sof   = 1'b0;
        d.o_eof   = 1'b0;
        d.o_err   = 1'b0;
        d.o_align = 1'b0;
        d.o_len   = '0;
        if (start_i) begin
            d.have_lo = 1'b1;
            d.lo      = rxd;
            d.pend    = 1'b0;
            d.first   = 1'b1;
            d.err     = rx_er;
            d.len     = '0;
        end else if (nib_i) begin
            d.err = q.err | rx_er;
            if (!q.have_lo) begin
                d.lo      = rxd;
                d.have_lo = 1'b1;
                if (q.pend) begin
                    d.o_valid = 1'b1;
                    d.o_data  = q.pend_byte;
                    d.o_sof   = q.first;
                    d.first   = 1'b0;
                    d.pend    = 1'b0;
                    d.len     = sat_inc(q.len);
                end
            end else begin
                d.pend_byte = {rxd, q.lo};
                d.pend      = 1'b1;
                d.have_lo   = 1'b0;
            end
        end else if (fin_i) begin
            d.o_valid = 1'b1;
            d.o_data  = q.have_lo ? {{NIB_W{1'b0}}, q.lo} : q.pend_byte;
            d.o_sof   = q.first;
            d.o_eof   = 1'b1;
            d.o_err   = q.err;
            d.o_align = q.have_lo;
            d.o_len   = sat_inc(q.len);
            d.have_lo = 1'b0;
            d.pend    = 1'b0;
            d.first   = 1'b0;
            d.err     = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign out_valid     = q.o_valid;
    assign out_data      = q.o_data;
    assign out_sof       = q.o_sof;
    assign out_eof       = q.o_eof;
    assign out_err       = q.o_err;
    assign out_align_err = q.o_align;
    assign out_len       = q.o_len;
endmodule

// File: rtl/mii_rx_framer.sv
module mii_rx_framer #(
    parameter int LEN_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_active,
    input  logic             rx_dv,
    input  logic             rx_er,
    input  logic [3:0]       rxd,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic             out_sof,
    output logic             out_eof,
    output logic             out_err,
    output logic             out_align_err,
    output logic [LEN_W-1:0] out_len
);
    logic start_w, nib_w, fin_w;

    mii_rx_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_dv     (rx_dv),
        .tx_active (tx_active),
        .start_o   (start_w),
        .nib_o     (nib_w),
        .fin_o     (fin_w)
    );

    mii_rx_assembler #(.LEN_W(LEN_W)) u_asm (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_w),
        .nib_i         (nib_w),
        .fin_i         (fin_w),
        .rxd           (rxd),
        .rx_er         (rx_er),
        .out_valid     (out_valid),
        .out_data      (out_data),
        .out_sof       (out_sof),
        .out_eof       (out_eof),
        .out_err       (out_err),
        .out_align_err (out_align_err),
        .out_len       (out_len)
    );
endmodule

// File: rtl/mii_rx_framer_chk.sv
module mii_rx_framer_chk #(
    parameter int LEN_W = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_dv,
    input logic             out_valid,
    input logic [7:0]       out_data,
    input logic             out_sof,
    input logic             out_eof,
    input logic             out_err,
    input logic             out_align_err,
    input logic [LEN_W-1:0] out_len
);
    logic open_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         open_q <= 1'b0;
        else if (out_valid) open_q <= !out_eof;
    end

    // R3: the first beat after a closed frame opens a new one
    a_r3_sof_opens: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !open_q |-> out_sof);

    // R3: no start marker inside an open frame
    a_r3_no_sof_inside: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && open_q |-> !out_sof);

    // R3: markers only ride on valid beats
    a_r3_markers_need_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !out_sof && !out_eof);

    // R6: an odd tail is padded with a zero upper nibble on the end beat
    a_r6_pad_on_odd: assert property (@(posedge clk) disable iff (!rst_n)
        out_align_err |-> out_eof && out_data[7:4] == 4'h0);

    // R7: status fields are zero away from the end beat
    a_r7_status_only_eof: assert property (@(posedge clk) disable iff (!rst_n)
        !out_eof |-> out_len == '0 && !out_err && !out_align_err);

    // R7: an end beat always reports at least one byte
    a_r7_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        out_eof |-> out_len != '0);

    // R11: two idle edges in a row leave the output quiet
    a_r11_quiet_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rx_dv) && !$past(rx_dv, 2) |-> !out_valid);
endmodule

bind mii_rx_framer mii_rx_framer_chk #(.LEN_W(LEN_W)) u_chk (.*);

// File: tb/tb_mii_rx_framer.sv
module tb_mii_rx_framer;
    localparam int LEN_W = 11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_active = 1'b0, rx_dv = 1'b0, rx_er = 1'b0;
    logic [3:0] rxd = 4'h0;
    logic out_valid, out_sof, out_eof, out_err, out_align_err;
    logic [7:0] out_data;
    logic [LEN_W-1:0] out_len;

    mii_rx_framer #(.LEN_W(LEN_W)) dut (.*);

    always #4 clk = ~clk;

    int total = 0, bad = 0, cyc = 0;
    bit done = 0;

    logic [3:0] nib [0:63];
    bit         er  [0:63];
    logic [7:0] cap_data [0:63];
    bit cap_sof [0:63], cap_eof [0:63], cap_err [0:63], cap_al [0:63];
    int cap_len [0:63];
    int cap_n = 0, cap_eof_cyc = -1, drop_cyc = 0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n && out_valid && cap_n < 64) begin
            cap_data[cap_n] = out_data;
            cap_sof[cap_n]  = out_sof;
            cap_eof[cap_n]  = out_eof;
            cap_err[cap_n]  = out_err;
            cap_al[cap_n]   = out_align_err;
            cap_len[cap_n]  = int'(out_len);
            if (out_eof) cap_eof_cyc = cyc;
            cap_n = cap_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_bytes(input int n);
        return (n + 1) / 2;
    endfunction

    function automatic logic [7:0] exp_byte(input int j, input int n);
        logic [3:0] hi;
        hi = (2 * j + 1 < n) ? nib[2 * j + 1] : 4'h0;
        return {hi, nib[2 * j]};
    endfunction

    function automatic bit exp_err(input int n);
        bit e = 0;
        for (int i = 0; i < n; i++) e |= er[i];
        return e;
    endfunction

    // Drive n nibbles; optionally pulse tx_active mid-frame (R9) or hold it at start (R8)
    task automatic drive(input int n, input bit tx_mid, input bit tx_start, input int gap);
        cap_n = 0;
        cap_eof_cyc = -1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_dv = 1'b1;
            rxd   = nib[i];
            rx_er = er[i];
            if (tx_start) tx_active = (i < n / 2) || (i == 0);
            else          tx_active = tx_mid && (i > 0) && (i == n / 2);
        end
        @(negedge clk);
        drop_cyc  = cyc;
        rx_dv     = 1'b0;
        tx_active = 1'b0;
        for (int g = 0; g < gap; g++) begin
            rxd   = 4'($urandom);
            rx_er = 1'($urandom);
            @(negedge clk);
        end
        rx_er = 1'b0;
    endtask

    task automatic check_frame(input int n, input string req);
        int nb;
        bit e;
        nb = exp_bytes(n);
        e  = exp_err(n);
        chk(cap_n == nb, "R4", {req, " beat count"}, cap_n, nb);
        for (int j = 0; j < nb && j < cap_n; j++) begin
            chk(cap_data[j] == exp_byte(j, n), "R2", "byte", int'(cap_data[j]), int'(exp_byte(j, n)));
            chk(cap_sof[j] == (j == 0), "R3", "sof", int'(cap_sof[j]), int'(j == 0));
            chk(cap_eof[j] == (j == nb - 1), "R3", "eof", int'(cap_eof[j]), int'(j == nb - 1));
            chk(cap_err[j] == ((j == nb - 1) && e), "R5", "err", int'(cap_err[j]), int'((j == nb - 1) && e));
            chk(cap_al[j] == ((j == nb - 1) && (n % 2 == 1)), "R6", "align",
                int'(cap_al[j]), int'((j == nb - 1) && (n % 2 == 1)));
            chk(cap_len[j] == ((j == nb - 1) ? nb : 0), "R7", "len", cap_len[j], (j == nb - 1) ? nb : 0);
        end
        chk(cap_eof_cyc == drop_cyc + 1, "R10", "eof cycle", cap_eof_cyc, drop_cyc + 1);
    endtask

    task automatic fill(input int n, input int er_at);
        for (int i = 0; i < n; i++) begin
            nib[i] = 4'($urandom);
            er[i]  = (er_at < 0) ? ($urandom % 8 == 0) : (i == er_at);
        end
    endtask

    initial begin
        void'($urandom(32'd48006));
        repeat (3) @(negedge clk);
        chk(!out_valid && !out_sof && !out_eof && !out_err && !out_align_err && out_len == 0,
            "R1", "outputs in reset", int'(out_valid), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!out_valid && out_len == 0, "R1", "outputs after reset", int'(out_valid), 0);

        // one nibble: padded single beat with both markers (R6, R3)
        fill(1, 99); drive(1, 0, 0, 3); check_frame(1, "R6 single nibble");
        // one byte, even (R3)
        fill(2, 99); drive(2, 0, 0, 3); check_frame(2, "R3 single byte");
        // three nibbles, error only on last nibble (R5, R4)
        fill(3, 2); drive(3, 0, 0, 3); check_frame(3, "R5 late error");
        // errors only while idle must not flag (R5)
        fill(8, 99); drive(8, 0, 0, 6); check_frame(8, "R5 idle error");
        // R9: tx_active pulses during an accepted frame
        fill(10, 99); drive(10, 1, 0, 3); check_frame(10, "R9 tx mid");
        // R8: echo event, tx drops midway
        fill(12, 99); drive(12, 0, 1, 3);
        chk(cap_n == 0, "R8", "beats on echo", cap_n, 0);
        // next frame after the echo is received normally (R8)
        fill(6, 99); drive(6, 0, 0, 3); check_frame(6, "R8 after echo");

        for (int k = 0; k < 60; k++) begin
            int n;
            int mode;
            n    = 1 + int'($urandom % 40);
            mode = int'($urandom % 6);
            fill(n, -1);
            if (mode == 0) begin
                drive(n, 0, 1, 2 + int'($urandom % 3));
                chk(cap_n == 0, "R8", "random echo", cap_n, 0);
            end else begin
                drive(n, mode == 1, 0, 2 + int'($urandom % 3));
                check_frame(n, "random");
            end
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=%0d exp=%0d", cyc, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule